// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit performs one bit-level operation per request on a data word. A request carries a word, a bit number and a two-bit operation code. The unit reports whether the chosen bit was clear before the operation, and it returns the word with that bit left alone, set, cleared or inverted. A size input picks the wrap rule for the bit number. In register mode the bit number wraps within the full word. In byte mode it wraps within the low byte, as when the operand is a single byte fetched from memory.

The result, the zero flag and a per-flag update enable are registered. They appear one cycle after the request strobe, together with a valid strobe. Only the zero flag is marked for update; the carry, overflow, negative and extend enables stay low. Operand fetch and write-back are handled outside the unit.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted and after it is released, valid_o, result_o, zero_o and flag_upd_o are all 0 until the first request.
- R2: valid_o is 1 exactly in the cycle after a cycle with req_i high, and is 0 otherwise.
- R3: Op code 2'b00 (test) returns the operand unchanged.
- R4: Op code 2'b11 (set) returns the operand with the selected bit forced to 1 and all other bits unchanged.
- R5: Op code 2'b10 (clear) returns the operand with the selected bit forced to 0 and all other bits unchanged.
- R6: Op code 2'b01 (change) returns the operand with the selected bit inverted and all other bits unchanged.
- R7: zero_o is 1 when the selected bit of the incoming operand was 0, and 0 when it was 1, for every op code.
- R8: With size_i = 0 (register operand), the selected bit is bitnum_i modulo 32.
- R9: With size_i = 1 (byte operand), the selected bit is bitnum_i modulo 8, and bits 31..8 are returned unchanged for every op code.
- R10: flag_upd_o has one enable per flag: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 extend. It is 5'b00100 whenever valid_o is 1 and 5'b00000 whenever valid_o is 0.
- R11: In a cycle after one with req_i low, result_o and zero_o hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation: 00 test, 01 change, 10 clear, 11 set |
| size_i | input | 1 | 0 register operand (wrap 32), 1 byte operand (wrap 8) |
| bitnum_i | input | NUM_W (6) | Requested bit number before wrapping |
| operand_i | input | DATA_W (32) | Operand word |
| valid_o | output | 1 | Result valid strobe |
| result_o | output | DATA_W (32) | Modified operand |
| zero_o | output | 1 | 1 when the selected bit was 0 before the operation |
| flag_upd_o | output | 5 | Per-flag update enable (C, V, Z, N, X from bit 0) |

## Verification
The bench uses the default parameters: a 32-bit word, an 8-bit byte and a 6-bit bit number. Because the bit number is 6 bits wide, it can reach values from 32 to 63 in register mode and from 8 to 63 in byte mode, so both wrap rules are exercised on numbers that actually wrap. Randomized back-to-back and gapped requests mix all four op codes with both sizes. This covers the hold behaviour between requests and the flag-enable pattern on both valid and idle cycles.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    typedef enum logic [1:0] {
        BOP_TEST = 2'b00,
        BOP_FLIP = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_SET  = 2'b11
    } bop_e;

    // flag enable vector positions, decoded by the flag register downstream
    localparam int FLAG_W = 5;
    localparam int FLAG_C = 0;
    localparam int FLAG_V = 1;
    localparam int FLAG_Z = 2;
    localparam int FLAG_N = 3;
    localparam int FLAG_X = 4;
endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 6,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int BIDX_W = $clog2(BYTE_W)
) (
    input  logic [NUM_W-1:0] bitnum_i,
    input  logic             size_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] word_idx;
    logic [IDX_W-1:0] byte_idx;

    // modulo by power of two: keep low bits only
    generate
        if (NUM_W >= IDX_W) begin : g_wide
            assign word_idx = bitnum_i[IDX_W-1:0];
        end else begin : g_narrow
            assign word_idx = IDX_W'(bitnum_i);
        end
    endgenerate

    assign byte_idx = IDX_W'(bitnum_i[BIDX_W-1:0]);

    always_comb begin
        idx_o = size_i ? byte_idx : word_idx;
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  bop_e              op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              old_bit_o
);
    logic [DATA_W-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_bit
            logic new_bit;
            assign hit[i] = (idx_i == IDX_W'(i));
            always_comb begin
                unique case (op_i)
                    BOP_TEST: new_bit = operand_i[i];
                    BOP_FLIP: new_bit = ~operand_i[i];
                    BOP_CLR:  new_bit = 1'b0;
                    BOP_SET:  new_bit = 1'b1;
                    default:  new_bit = operand_i[i];
                endcase
            end
            assign result_o[i] = hit[i] ? new_bit : operand_i[i];
        end
    endgenerate

    assign old_bit_o = |(operand_i & hit);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [1:0]          op_i,
    input  logic                size_i,
    input  logic [NUM_W-1:0]    bitnum_i,
    input  logic [DATA_W-1:0]   operand_i,
    output logic                valid_o,
    output logic [DATA_W-1:0]   result_o,
    output logic                zero_o,
    output logic [FLAG_W-1:0]   flag_upd_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [FLAG_W-1:0] Z_ONLY = FLAG_W'(1) << FLAG_Z;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              zero;
        logic [FLAG_W-1:0] upd;
    } state_t;

    state_t           st_d, st_q;
    logic [IDX_W-1:0] sel_idx;
    logic [DATA_W-1:0] alu_res;
    logic             alu_old;

    bitop_index #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .NUM_W  (NUM_W)
    ) u_index (
        .bitnum_i (bitnum_i),
        .size_i   (size_i),
        .idx_o    (sel_idx)
    );

    bitop_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .operand_i (operand_i),
        .idx_i     (sel_idx),
        .op_i      (bop_e'(op_i)),
        .result_o  (alu_res),
        .old_bit_o (alu_old)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_i;
        st_d.upd   = req_i ? Z_ONLY : '0;
        if (req_i) begin
            st_d.result = alu_res;
            st_d.zero   = ~alu_old;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o    = st_q.valid;
    assign result_o   = st_q.result;
    assign zero_o     = st_q.zero;
    assign flag_upd_o = st_q.upd;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_i,
    input logic [1:0]          op_i,
    input logic                size_i,
    input logic [NUM_W-1:0]    bitnum_i,
    input logic [DATA_W-1:0]   operand_i,
    input logic                valid_o,
    input logic [DATA_W-1:0]   result_o,
    input logic                zero_o,
    input logic [FLAG_W-1:0]   flag_upd_o
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int BIDX_W = $clog2(BYTE_W);

    logic [IDX_W-1:0] ck_idx;
    logic             ck_old;
    assign ck_idx = size_i ? IDX_W'(bitnum_i[BIDX_W-1:0]) : IDX_W'(bitnum_i);
    assign ck_old = operand_i[ck_idx];

    // R2
    req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    // R2
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);
    // R3
    test_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'b00) |=> result_o == $past(operand_i));
    // R4
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'b11) |=> result_o[$past(ck_idx)] == 1'b1);
    // R5
    clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'b10) |=> result_o[$past(ck_idx)] == 1'b0);
    // R6
    flip_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'b01) |=> $countones(result_o ^ $past(operand_i)) == 1);
    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> zero_o == !$past(ck_old));
    // R9
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && size_i) |=> result_o[DATA_W-1:BYTE_W] == $past(operand_i[DATA_W-1:BYTE_W]));
    // R10
    flag_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (flag_upd_o == (FLAG_W'(1) << FLAG_Z)));
    // R10
    flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> flag_upd_o == '0);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(result_o) && $stable(zero_o)));
endmodule

bind bitop_unit bitop_unit_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .NUM_W  (NUM_W)
) u_chk (.*);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic          size_i = 1'b0;
    logic [NW-1:0] bitnum_i = '0;
    logic [DW-1:0] operand_i = '0;
    logic          valid_o;
    logic [DW-1:0] result_o;
    logic          zero_o;
    logic [4:0]    flag_upd_o;

    int checks = 0;
    int errors = 0;

    logic          e_valid = 1'b0;
    logic [DW-1:0] e_result = '0;
    logic          e_zero = 1'b0;
    string         e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .size_i(size_i),
        .bitnum_i(bitnum_i), .operand_i(operand_i), .valid_o(valid_o),
        .result_o(result_o), .zero_o(zero_o), .flag_upd_o(flag_upd_o)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 valid", DW'(valid_o), DW'(e_valid));
        chk({e_tag, " result"}, result_o, e_result);
        chk({e_tag, " R7 zero"}, DW'(zero_o), DW'(e_zero));
        chk("R10 flag_upd", DW'(flag_upd_o), e_valid ? DW'(5'b00100) : DW'(0));
    endtask

    // behavioural model, updated with the stimulus just applied
    task automatic model(input logic rq, input logic [1:0] op, input logic sz,
                         input int bn, input logic [DW-1:0] opd);
        int pos;
        logic old;
        e_valid = rq;
        if (!rq) begin
            e_tag = "R11";
            return;
        end
        pos = sz ? (bn % 8) : (bn % 32);
        old = opd[pos];
        e_result = opd;
        case (op)
            2'b00: begin e_tag = "R3"; end
            2'b01: begin e_tag = "R6"; e_result[pos] = ~old; end
            2'b10: begin e_tag = "R5"; e_result[pos] = 1'b0; end
            default: begin e_tag = "R4"; e_result[pos] = 1'b1; end
        endcase
        e_tag = {e_tag, sz ? " R9" : " R8"};
        e_zero = ~old;
    endtask

    // one cycle: compare outputs of previous stimulus, then drive new one
    task automatic step(input logic rq, input logic [1:0] op, input logic sz,
                        input int bn, input logic [DW-1:0] opd);
        @(negedge clk);
        compare_all();
        req_i = rq; op_i = op; size_i = sz; bitnum_i = NW'(bn); operand_i = opd;
        model(rq, op, sz, bn, opd);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R1 reset state
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R3..R6 with R8 wrap: bit 37 -> bit 5
        step(1, 2'b00, 0, 37, 32'h0000_0020);
        step(1, 2'b11, 0, 37, 32'h0000_0000);
        step(1, 2'b10, 0, 37, 32'hFFFF_FFFF);
        step(1, 2'b01, 0, 63, 32'h8000_0000);   // R8: 63 -> bit 31
        step(1, 2'b01, 0, 31, 32'h0000_0000);
        // R9 byte wrap: 12 -> bit 4, upper bits untouched
        step(1, 2'b11, 1, 12, 32'hABCD_EF00);
        step(1, 2'b10, 1, 63, 32'h1234_56FF);  // 63 -> bit 7
        step(1, 2'b01, 1, 8,  32'hFFFF_FF00);  // 8 -> bit 0
        step(1, 2'b00, 1, 15, 32'h0000_0080);
        // R11 hold across idle cycles with changing inputs
        step(0, 2'b11, 0, 3, 32'h5555_5555);
        step(0, 2'b01, 1, 9, 32'hAAAA_AAAA);
        step(1, 2'b00, 0, 0, 32'h0000_0000);   // R7 zero on clear bit

        for (int n = 0; n < 3000; n++) begin
            logic rq;
            rq = ($urandom_range(0, 3) != 0);
            step(rq, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 63)), $urandom());
        end
        step(0, 2'b00, 0, 0, '0);
        @(negedge clk);
        compare_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule